// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction in the execute stage of a five-stage in-order pipeline, where that operand's value should come from. There are three possible sources: the register file, the result held by the instruction one stage ahead (execute/memory), or the result held by the instruction two stages ahead (memory/writeback). A dependent instruction placed directly behind the instruction that produces its value can therefore run without inserted no-op bubbles.

Each operand's source register number is compared with the destination number of both older in-flight instructions. A comparison counts only when that older instruction really writes a register and its destination is not register 0. When both older instructions match, the nearer one (execute/memory) wins, because it carries the newer value. The wrapper captures all inputs in a register on each rising clock edge. This register stands in for the pipeline registers. The selects are decoded from the captured values, so they appear one clock after the inputs are presented.

Top module: `byp_fwd_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both selects read 2'b00 after that edge, whatever the other inputs are.
- R2: Operand 0 select is 2'b10 when `mem_we_i` is 1, `mem_dst_i` is nonzero and `mem_dst_i` equals `ex_src0_i`.
- R3: Operand 1 select is 2'b10 when `mem_we_i` is 1, `mem_dst_i` is nonzero and `mem_dst_i` equals `ex_src1_i`.
- R4: An operand's select is 2'b01 when the R2/R3 condition for that operand is false, `wb_we_i` is 1, `wb_dst_i` is nonzero and `wb_dst_i` equals that operand's source.
- R5: A stage whose write-enable is 0 never causes forwarding, even when its destination equals a source.
- R6: A destination of 0 never causes forwarding, even when the stage's write-enable is 1 and a source is 0.
- R7: When both stages qualify for an operand, execute/memory wins and the select is 2'b10.
- R8: With no qualifying match, an operand's select is 2'b00 (register file). The value 2'b11 never appears.
- R9: The selects change only at a rising edge. They reflect the inputs sampled at the most recent edge and stay steady while the inputs change between edges.
- R10: Each operand is resolved on its own. Both operands may forward from different stages, or from the same stage, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src0_i | input | REG_W | First source register number of the execute-stage instruction |
| ex_src1_i | input | REG_W | Second source register number of the execute-stage instruction |
| mem_dst_i | input | REG_W | Destination register of the execute/memory instruction |
| mem_we_i | input | 1 | Execute/memory instruction writes a register |
| wb_dst_i | input | REG_W | Destination register of the memory/writeback instruction |
| wb_we_i | input | 1 | Memory/writeback instruction writes a register |
| op0_sel_o | output | 2 | Operand 0 source: 00 register file, 10 execute/memory, 01 memory/writeback |
| op1_sel_o | output | 2 | Operand 1 source, same encoding |

## Verification
Directed vectors cover each case on its own:
- a hit from one stage only, on each operand separately;
- a hit from both stages at once, which separates the priority order from a plain OR of the two hits;
- a matching destination with its write-enable low, which separates qualified compares from bare equality;
- register 0 as both source and destination, which exposes a missing zero-register guard.

Random vectors draw register numbers from a small set so that matches, double hits and zero registers occur often. Those vectors are checked against a reference function written from the requirements. A mid-cycle input change confirms that the selects move only at the clock edge.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } byp_src_e;
endpackage

// File: rtl/byp_stage_regs.sv
module byp_stage_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("reset did not clear captured inputs");
endmodule

// File: rtl/byp_match.sv
module byp_match #(
  parameter int REG_W = 5
) (
  input  logic             we,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = we && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/byp_opnd_sel.sv
module byp_opnd_sel
  import byp_pkg::*;
(
  input  logic       mem_hit,
  input  logic       wb_hit,
  output logic [1:0] sel
);
  byp_src_e choice;

  always_comb begin
    if (mem_hit)     choice = SRC_MEM;
    else if (wb_hit) choice = SRC_WB;
    else             choice = SRC_RF;
    sel = choice;
  end

  // R8: encoding 2'b11 is never produced
  always_comb begin
    assert_no_illegal_sel_R8: assert (sel != 2'b11)
      else $error("illegal select value");
  end
endmodule

// File: rtl/byp_fwd_unit.sv
module byp_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ex_src0_i,
  input  logic [REG_W-1:0] ex_src1_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_we_i,
  output logic [1:0]       op0_sel_o,
  output logic [1:0]       op1_sel_o
);
  localparam int NSRC     = 2;
  localparam int BUNDLE_W = NSRC*REG_W + 2*(REG_W + 1);

  logic [BUNDLE_W-1:0] bundle_d, bundle_q;
  logic [REG_W-1:0]    src_q [NSRC];
  logic [REG_W-1:0]    mem_dst_q, wb_dst_q;
  logic                mem_we_q, wb_we_q;
  logic [1:0]          sel [NSRC];

  assign bundle_d = {ex_src1_i, ex_src0_i, mem_we_i, mem_dst_i, wb_we_i, wb_dst_i};

  byp_stage_regs #(.W(BUNDLE_W)) u_stage (
    .clk (clk),
    .rst (rst),
    .d   (bundle_d),
    .q   (bundle_q)
  );

  assign {src_q[1], src_q[0], mem_we_q, mem_dst_q, wb_we_q, wb_dst_q} = bundle_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_opnd
    logic mem_hit, wb_hit;

    byp_match #(.REG_W(REG_W)) u_mem_cmp (
      .we  (mem_we_q),
      .dst (mem_dst_q),
      .src (src_q[i]),
      .hit (mem_hit)
    );

    byp_match #(.REG_W(REG_W)) u_wb_cmp (
      .we  (wb_we_q),
      .dst (wb_dst_q),
      .src (src_q[i]),
      .hit (wb_hit)
    );

    byp_opnd_sel u_sel (
      .mem_hit (mem_hit),
      .wb_hit  (wb_hit),
      .sel     (sel[i])
    );
  end

  assign op0_sel_o = sel[0];
  assign op1_sel_o = sel[1];

  // Port-level checks across the capture register
  assert_mem_fwd_op0_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we_i && mem_dst_i != '0 && mem_dst_i == ex_src0_i) |=> (op0_sel_o == 2'b10))
    else $error("operand 0 not taken from execute/memory");

  assert_mem_fwd_op1_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we_i && mem_dst_i != '0 && mem_dst_i == ex_src1_i) |=> (op1_sel_o == 2'b10))
    else $error("operand 1 not taken from execute/memory");

  assert_wb_fwd_op0_R4: assert property (@(posedge clk) disable iff (rst)
    (!(mem_we_i && mem_dst_i != '0 && mem_dst_i == ex_src0_i) &&
     wb_we_i && wb_dst_i != '0 && wb_dst_i == ex_src0_i) |=> (op0_sel_o == 2'b01))
    else $error("operand 0 not taken from memory/writeback");

  assert_no_we_no_fwd_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_i && !wb_we_i) |=> (op0_sel_o == 2'b00 && op1_sel_o == 2'b00))
    else $error("forwarding without a register write");

  assert_zero_dst_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_dst_i == '0 && wb_dst_i == '0) |=> (op0_sel_o == 2'b00 && op1_sel_o == 2'b00))
    else $error("forwarding from register 0");
endmodule

// File: tb/sim_byp_fwd_unit.sv
module sim_byp_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;
  localparam int WATCHDOG   = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [REG_W-1:0] s0 = '0, s1 = '0, md = '0, wd = '0;
  logic             mw = 1'b0, ww = 1'b0;
  logic [1:0]       o0, o1;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byp_fwd_unit #(.REG_W(REG_W)) u0 (
    .clk(clk), .rst(rst),
    .ex_src0_i(s0), .ex_src1_i(s1),
    .mem_dst_i(md), .mem_we_i(mw),
    .wb_dst_i(wd), .wb_we_i(ww),
    .op0_sel_o(o0), .op1_sel_o(o1)
  );

  function automatic logic [1:0] ref_sel(logic [REG_W-1:0] src, logic [REG_W-1:0] mdst,
                                         logic mwe, logic [REG_W-1:0] wdst, logic wwe);
    if (mwe && mdst != 0 && mdst == src) return 2'b10;
    if (wwe && wdst != 0 && wdst == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [REG_W-1:0] a, logic [REG_W-1:0] b, logic [REG_W-1:0] m,
                       logic me, logic [REG_W-1:0] w, logic we, string tag);
    @(negedge clk);
    s0 = a; s1 = b; md = m; mw = me; wd = w; ww = we;
    @(posedge clk);
    #1;
    check({tag, " op0"}, o0, ref_sel(a, m, me, w, we));
    check({tag, " op1"}, o1, ref_sel(b, m, me, w, we));
  endtask

  initial begin
    int unsigned seed = 32'd7;
    void'($urandom(seed));
    // R1: reset with matching inputs applied
    rst = 1'b1; s0 = 5'd3; s1 = 5'd3; md = 5'd3; mw = 1'b1; wd = 5'd3; ww = 1'b1;
    @(posedge clk); #1;
    check("R1 reset op0", o0, 2'b00);
    check("R1 reset op1", o1, 2'b00);
    @(negedge clk); rst = 1'b0;

    apply(5'd4, 5'd9, 5'd4, 1, 5'd20, 1, "R2 mem->op0");
    apply(5'd8, 5'd6, 5'd6, 1, 5'd21, 1, "R3 mem->op1");
    apply(5'd11, 5'd2, 5'd30, 1, 5'd11, 1, "R4 wb->op0");
    apply(5'd2, 5'd11, 5'd30, 1, 5'd11, 1, "R4 wb->op1");
    apply(5'd7, 5'd7, 5'd7, 0, 5'd7, 0, "R5 no write");
    apply(5'd7, 5'd5, 5'd7, 0, 5'd5, 1, "R5 mem disabled");
    apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, "R6 zero reg");
    apply(5'd0, 5'd3, 5'd0, 1, 5'd3, 1, "R6 zero mem");
    apply(5'd12, 5'd12, 5'd12, 1, 5'd12, 1, "R7 both hit");
    apply(5'd1, 5'd2, 5'd3, 1, 5'd4, 1, "R8 no match");
    apply(5'd13, 5'd14, 5'd13, 1, 5'd14, 1, "R10 split");
    apply(5'd15, 5'd15, 5'd15, 1, 5'd1, 1, "R10 same stage");

    // R9: mid-cycle change must not move outputs before the edge
    apply(5'd9, 5'd9, 5'd9, 1, 5'd2, 1, "R9 setup");
    @(negedge clk);
    s0 = 5'd2; s1 = 5'd2; md = 5'd18;
    #1;
    check("R9 hold op0", o0, 2'b10);
    check("R9 hold op1", o1, 2'b10);
    @(posedge clk); #1;
    check("R9 update op0", o0, 2'b01);
    check("R9 update op1", o1, 2'b01);

    for (int k = 0; k < 600; k++) begin
      apply(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
            REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R10 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule